// File: doc/BRIEF.md
# Sample-and-Recheck Switch Debouncer

This block cleans up a single bouncing mechanical switch input. The raw level first passes through a synchroniser. The synchronised level is then compared with the debounced output on every cycle. When the two differ, the block records the new level as a candidate and starts a fixed wait of `WAIT_CYCLES` clock cycles. At the end of the wait it samples the synchronised input once more. The output takes the candidate only if that single sample still agrees with it. If the sample disagrees, the block drops the candidate and returns to watching.

The wait is a single sample taken at a fixed point in time. It is not a window that restarts on every bounce. Activity in the middle of the wait therefore has no influence on the result. `WAIT_CYCLES` can be a few cycles for simulation, or about 10 ms worth of cycles for a real switch. A one-cycle strobe marks each update of the output. Each switch gets its own instance, and the debounced level and its strobe feed ordinary synchronous logic.

Top module: `sw_debounce`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `clean_out` equals the parameter `IDLE_LEVEL`, `change_pulse` is 0, and the block is watching.
- R2: The raw input passes through `SYNC_STAGES` (default 2) flip-flops before any comparison. A raw level that differs from `clean_out` and holds steady is first captured by rising edge 1. It reaches `clean_out` on rising edge `WAIT_CYCLES + SYNC_STAGES + 1` (edge 6 with the defaults).
- R3: When the synchronised input differs from `clean_out` while the block is watching, the block stores that level as the candidate and waits exactly `WAIT_CYCLES` cycles before deciding. `WAIT_CYCLES` must be at least 1.
- R4: If the synchronised input no longer equals the candidate at the end of the wait, `clean_out` keeps its value, no strobe is produced, and the block resumes watching.
- R5: Input changes during the wait have no effect. Only the level sampled at the end of the wait decides. For example, with the defaults a one-cycle return of the raw input, captured by rising edge 3 while a change is pending, does not move or delay the update on edge 6.
- R6: `change_pulse` is 1 for exactly the one cycle in which `clean_out` has just taken a new value. It is 0 on every other cycle.
- R7: While the synchronised input equals `clean_out`, no check starts, and `clean_out` and `change_pulse` stay quiet.
- R8: The wait counter is sized from `WAIT_CYCLES`. The same behaviour holds for any `WAIT_CYCLES` ≥ 1, including 1, and for either `IDLE_LEVEL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 1 | Unsynchronised switch level |
| clean_out | output | 1 | Debounced, registered level |
| change_pulse | output | 1 | One-cycle strobe when `clean_out` updates |

## Verification
The bench measures the exact edge on which a held change appears. A design that miscounts the synchroniser or the wait would update one edge early or late. A single-cycle dip starts a check that must then be rejected: a debouncer that commits the candidate without rechecking would follow the dip. A one-cycle glitch placed inside a pending wait must be ignored: a design that restarts or aborts on any movement would delay or lose the update. A second instance with a one-cycle wait and a high idle level covers the shortest counter and the reset level. Long random bounce trains are compared, cycle by cycle, against a bench model of the requirements.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_HOLD  = 1'b1
  } dbnc_state_e;

  // Width of a down-counter that must hold values 0 .. n-1.
  function automatic int unsigned wait_cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RESET_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

  // R2: the last stage only repeats what the stage before it held
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q == $past(pipe[STAGES-2]));

endmodule

// File: rtl/dbnc_timer.sv
module dbnc_timer
  import dbnc_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  localparam int unsigned CW = wait_cnt_width(WAIT_CYCLES);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (load)     cnt <= LOAD_VAL;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: the counter never leaves its range
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD_VAL);

  // R3: a load starts a full wait
  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == LOAD_VAL);

endmodule

// File: rtl/sw_debounce.sv
module sw_debounce
  import dbnc_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 3,
  parameter logic        IDLE_LEVEL  = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic clean_out,
  output logic change_pulse
);

  dbnc_state_e state;
  logic        sync_q;
  logic        cand_q;
  logic        out_q;
  logic        pulse_q;
  logic        start_wait;
  logic        expired;

  dbnc_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(IDLE_LEVEL)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_in),
    .q  (sync_q)
  );

  assign start_wait = (state == ST_WATCH) && (sync_q != out_q);

  dbnc_timer #(
    .WAIT_CYCLES(WAIT_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (start_wait),
    .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_WATCH;
      cand_q  <= IDLE_LEVEL;
      out_q   <= IDLE_LEVEL;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      unique case (state)
        ST_WATCH: begin
          if (start_wait) begin
            cand_q <= sync_q;
            state  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (expired) begin
            state <= ST_WATCH;
            if (sync_q == cand_q) begin
              out_q   <= cand_q;
              pulse_q <= 1'b1;
            end
          end
        end
        default: state <= ST_WATCH;
      endcase
    end
  end

  assign clean_out    = out_q;
  assign change_pulse = pulse_q;

  // R5: nothing moves before the wait has run out
  p_quiet_in_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !expired) |=> ($stable(clean_out) && !change_pulse));

  // R4: a failed recheck leaves the output alone and resumes watching
  p_reject_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && expired && sync_q != cand_q)
      |=> ($stable(clean_out) && state == ST_WATCH && !change_pulse));

  // R6: every strobe marks a real update
  p_pulse_marks_change_r6: assert property (@(posedge clk) disable iff (rst)
    change_pulse |-> (clean_out != $past(clean_out)));

  // R6: every update carries a strobe
  p_change_has_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (clean_out != $past(clean_out)) |-> change_pulse);

  // R6: strobe lasts one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    change_pulse |=> !change_pulse);

  // R7: agreement keeps the block watching
  p_steady_watch_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WATCH && sync_q == clean_out) |=> state == ST_WATCH);

endmodule

// File: tb/tb_sw_debounce.sv
module tb_dbnc_ref #(
  parameter int unsigned N    = 3,
  parameter logic        IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic ref_out,
  output logic ref_pulse
);
  logic s1, s2, busy, cand;
  int   left;

  always @(posedge clk) begin
    if (rst) begin
      s1 <= IDLE; s2 <= IDLE; busy <= 1'b0; cand <= IDLE;
      left <= 0; ref_out <= IDLE; ref_pulse <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      ref_pulse <= 1'b0;
      if (!busy) begin
        if (s2 != ref_out) begin
          busy <= 1'b1; cand <= s2; left <= N;
        end
      end else if (left == 1) begin
        busy <= 1'b0;
        if (s2 == cand) begin
          ref_out <= cand; ref_pulse <= 1'b1;
        end
      end else begin
        left <= left - 1;
      end
    end
  end
endmodule

module tb_sw_debounce;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic out_a, pulse_a, out_b, pulse_b;
  logic ref_out_a, ref_pulse_a, ref_out_b, ref_pulse_b;
  logic cmp_en = 1'b0;
  int   vectors = 0;
  int   fails = 0;
  int   cycles = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  sw_debounce #(.WAIT_CYCLES(3), .IDLE_LEVEL(1'b0)) dut (
    .clk(clk), .rst(rst), .raw_in(raw), .clean_out(out_a), .change_pulse(pulse_a));

  sw_debounce #(.WAIT_CYCLES(1), .IDLE_LEVEL(1'b1)) dut_n1 (
    .clk(clk), .rst(rst), .raw_in(raw), .clean_out(out_b), .change_pulse(pulse_b));

  tb_dbnc_ref #(.N(3), .IDLE(1'b0)) ref_a (
    .clk(clk), .rst(rst), .raw(raw), .ref_out(ref_out_a), .ref_pulse(ref_pulse_a));

  tb_dbnc_ref #(.N(1), .IDLE(1'b1)) ref_b (
    .clk(clk), .rst(rst), .raw(raw), .ref_out(ref_out_b), .ref_pulse(ref_pulse_b));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // Cycle-by-cycle comparison against the requirement model (R2 R3 R4 R5 R6 R8)
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk("R2_R5 out N=3", out_a, ref_out_a);
      chk("R6 pulse N=3", pulse_a, ref_pulse_a);
      chk("R3_R8 out N=1", out_b, ref_out_b);
      chk("R6 pulse N=1", pulse_b, ref_pulse_b);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      finish_run();
    end
  end

  initial begin
    int first_a, first_b, pulse_at, pulse_after, bad;
    void'($urandom(32'h5EED_0042));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 out idle N=3", out_a, 0);
    chk("R1 pulse N=3", pulse_a, 0);
    chk("R1 out idle N=1", out_b, 1);
    rst = 1'b0;
    chk("R1 pulse N=1", pulse_b, 0);
    @(negedge clk);
    chk("R1 out first cycle after reset", out_a, 0);
    repeat (20) @(negedge clk);

    // R2 / R3 / R8: latency of a clean change, both parameter sets
    raw = 1'b1;
    first_a = -1; first_b = -1; pulse_at = 0; pulse_after = 1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (first_a < 0 && out_a) begin first_a = k; pulse_at = pulse_a; end
      else if (first_a > 0 && k == first_a + 1) pulse_after = pulse_a;
      if (first_b < 0 && out_b) first_b = k;
    end
    chk("R2 update edge N=3", first_a, 6);
    chk("R3_R8 update edge N=1", first_b, 4);
    chk("R6 pulse on update", pulse_at, 1);
    chk("R6 pulse cleared next cycle", pulse_after, 0);
    repeat (5) @(negedge clk);

    // R4: a one-cycle dip starts a check that must be rejected
    raw = 1'b0;
    @(negedge clk);
    raw = 1'b1;
    bad = 0;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (out_a != 1'b1 || pulse_a) bad++;
    end
    chk("R4 rejected recheck keeps output", bad, 0);

    // R5: glitch inside the wait does not move the update
    raw = 1'b0;
    @(negedge clk);
    @(negedge clk);
    raw = 1'b1;
    @(negedge clk);
    raw = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 still high before edge 6", out_a, 1);
    @(negedge clk);
    chk("R5 low on edge 6 despite glitch", out_a, 0);
    chk("R6 pulse with glitch update", pulse_a, 1);

    // R7: steady input gives no activity
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pulse_a || pulse_b || out_a || out_b) bad++;
    end
    chk("R7 steady input quiet", bad, 0);

    // Random bounce trains checked against the model
    cmp_en = 1'b1;
    for (int burst = 0; burst < 600; burst++) begin
      raw = 1'($urandom_range(0, 1));
      repeat ($urandom_range(1, 10)) @(negedge clk);
    end
    cmp_en = 1'b0;
    finish_run();
  end
endmodule